// File: doc/BRIEF.md
# Section Parity Monitor and Inserter (B1 / B2)

This block watches one direction of a synchronous transport frame stream, presented one byte per clock with its row and column already known. It keeps two bit-interleaved parities at once. The regenerator-section parity is one byte. It is taken over every byte of a frame as that byte appears on the line, after scrambling. The multiplex-section parity is 3N bytes wide, so 24N bits in total. It is taken over the descrambled bytes of every row below the regenerator overhead. Each lane takes every 3N-th byte in column order. The accumulated values are frozen at each frame start, which makes them the reference for the frame that follows.

On the receive side, the block compares the frozen values with the parity bytes that arrive in the next frame. It reports the number of mismatching bits once per frame for each parity. On the transmit side, the same instance can overwrite those byte positions with the frozen values on a registered copy of the stream. It also places the most recent multiplex-section error count in the remote-error byte for the far end. The scrambler and the frame aligner sit outside the block.

Top module: `section_bip_monitor`

## Requirements
- R1: The regenerator parity is the even parity, bit by bit, over the `line_byte` input of every valid byte of a frame (row 0 column 0 up to the last byte). It is frozen when the next frame's row 0 column 0 byte is accepted. When insertion is enabled, it replaces the byte at row 1 column 0 on `out_byte`.
- R2: The multiplex parity has 3N lanes. Lane k is the even parity of `data_byte` over every valid byte in rows 3 to 8 whose column modulo 3N equals k. It is frozen at the same moment as R1. When insertion is enabled, lane k replaces the byte at row 4 column k.
- R3: One cycle after the byte at row 1 column 0 is accepted, `b1_err_vld` pulses for one cycle. `b1_err_cnt` then holds the number of ones in the frozen regenerator parity XOR `data_byte` (range 0 to 8).
- R4: One cycle after the byte at row 4 column 3N-1 is accepted, `b2_err_vld` pulses for one cycle. `b2_err_cnt` then holds the sum, over all lanes k, of the ones in lane k XOR the `data_byte` at row 4 column k (range 0 to 24N).
- R5: Neither a count pulse nor a parity insertion happens until a full frame has been accumulated, which means the second frame start after reset.
- R6: Errors on `line_byte` affect only the regenerator count. Errors on `data_byte` in rows 0 to 2 (outside the two parity positions) affect neither count. Errors on `data_byte` in rows 3 to 8 affect only the multiplex count.
- R7: `out_byte` and `out_vld` follow `data_byte` and `byte_vld` with one cycle of latency. With `ins_en` low, the byte passes through unchanged.
- R8: With `ins_en` high, the byte at row 8 column 5 is replaced by the last reported `b2_err_cnt`, held at 255 if it is larger (0 after reset).
- R9: During reset, `out_vld`, `out_byte`, both counts and both pulses are 0.
- R10: Cycles with `byte_vld` low are ignored. They do not change either parity or the frame start, and they produce `out_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Byte and position inputs are valid |
| row | input | ROW_W (4) | Row of the current byte, 0..8 |
| col | input | COL_W (9) | Column of the current byte, 0..270N-1 |
| line_byte | input | 8 | Byte in the scrambled (line) domain |
| data_byte | input | 8 | Same position in the descrambled domain |
| ins_en | input | 1 | Overwrite parity and remote-error bytes on the output |
| b1_err_cnt | output | 4 | Regenerator parity bit errors of the last check |
| b1_err_vld | output | 1 | One-cycle pulse: new regenerator count |
| b2_err_cnt | output | B2_CW (5) | Multiplex parity bit errors of the last check |
| b2_err_vld | output | 1 | One-cycle pulse: new multiplex count |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Registered stream with optional insertion |

## Verification
The first frame after reset is the main trap. A design that arms on the first frame start reports a garbage count and inserts a stale parity, and the bench sees this both on the pulses and on the output stream. Domain mix-ups are checked by single-byte corruption. A flipped line byte must raise only the regenerator count, and a flipped descrambled byte in the overhead rows must raise nothing. A design that feeds one parity from the wrong stream, or counts the overhead rows into the multiplex parity, reports a nonzero count where zero is expected. The bench also inserts idle cycles that carry a fake frame-start position, and it checks the fully inverted case of 24 errors. The first would restart a design that ignores the valid bit. The second would wrap a count register that is too narrow.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   localparam int OCTET_W = 8;

   function automatic logic [3:0] ones8(input logic [OCTET_W-1:0] v);
      logic [3:0] n;
      n = '0;
      for (int i = 0; i < OCTET_W; i++) n = n + 4'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/sbm_bip_acc.sv
module sbm_bip_acc #(
   parameter int LANES  = 3,
   parameter int LANE_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic                 sof,
   input  logic                 in_region,
   input  logic [LANE_W-1:0]    lane,
   input  logic [7:0]           din,
   output logic [LANES*8-1:0]   par_lat,
   output logic                 armed
);
   logic started;
   logic [7:0] acc_q [LANES];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic hit;
         assign hit = in_region && (lane == LANE_W'(l));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q[l]           <= '0;
               par_lat[l*8 +: 8]  <= '0;
            end else if (in_vld) begin
               if (sof) begin
                  acc_q[l] <= hit ? din : 8'h00;
                  if (started) par_lat[l*8 +: 8] <= acc_q[l];
               end else if (hit) begin
                  acc_q[l] <= acc_q[l] ^ din;
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started <= 1'b0;
         armed   <= 1'b0;
      end else if (in_vld && sof) begin
         started <= 1'b1;
         armed   <= started;
      end
   end

   // R5: arming only ever follows an accepted frame start
   a_r5_arm_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(in_vld && sof));
   // R1: the frozen parity moves only at an accepted frame start
   a_r1_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_vld && sof) |=> $stable(par_lat));
endmodule

// File: rtl/sbm_err_check.sv
module sbm_err_check
   import sbm_pkg::*;
#(
   parameter int LANES  = 3,
   parameter int LANE_W = 2,
   parameter int CW     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic                 hit,
   input  logic [LANE_W-1:0]    lane,
   input  logic [7:0]           din,
   input  logic [LANES*8-1:0]   par_lat,
   input  logic                 armed,
   output logic [CW-1:0]        err_cnt,
   output logic                 err_vld
);
   logic [CW-1:0] sum_q;
   logic [CW-1:0] part;
   logic [7:0]    ref_b;
   logic [3:0]    cur;

   always_comb begin
      ref_b = '0;
      for (int i = 0; i < LANES; i++)
         if (lane == LANE_W'(i)) ref_b = par_lat[i*8 +: 8];
      cur  = ones8(ref_b ^ din);
      part = ((lane == '0) ? '0 : sum_q) + CW'(cur);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q   <= '0;
         err_cnt <= '0;
         err_vld <= 1'b0;
      end else begin
         err_vld <= 1'b0;
         if (in_vld && hit && armed) begin
            if (lane == LANE_W'(LANES - 1)) begin
               err_cnt <= part;
               err_vld <= 1'b1;
               sum_q   <= '0;
            end else begin
               sum_q <= part;
            end
         end
      end
   end

   // R3/R4: a count never exceeds the number of covered bits
   a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |-> (err_cnt <= CW'(8 * LANES)));
   // R5: no report without a frozen reference
   a_r5_chk_armed: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |-> armed);
   // R3: a report is a single-cycle pulse
   a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |=> !err_vld);
endmodule

// File: rtl/sbm_ovh_insert.sv
module sbm_ovh_insert #(
   parameter int LANES  = 3,
   parameter int LANE_W = 2,
   parameter int CW     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic [7:0]           din,
   input  logic                 ins_en,
   input  logic                 is_b1,
   input  logic                 is_b2,
   input  logic                 is_m1,
   input  logic [LANE_W-1:0]    lane,
   input  logic [7:0]           b1_lat,
   input  logic [LANES*8-1:0]   b2_lat,
   input  logic                 b1_armed,
   input  logic                 b2_armed,
   input  logic [CW-1:0]        rei_cnt,
   input  logic                 rei_vld,
   output logic                 out_vld,
   output logic [7:0]           out_byte
);
   logic [CW-1:0] rei_q;
   logic [7:0]    rei_byte;
   logic [7:0]    b2_sel;

   generate
      if (8 * LANES > 255) begin : g_sat
         assign rei_byte = (rei_q > CW'(255)) ? 8'hFF : rei_q[7:0];
      end else begin : g_nosat
         assign rei_byte = 8'(rei_q);
      end
   endgenerate

   always_comb begin
      b2_sel = '0;
      for (int i = 0; i < LANES; i++)
         if (lane == LANE_W'(i)) b2_sel = b2_lat[i*8 +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_byte <= '0;
         rei_q    <= '0;
      end else begin
         out_vld <= in_vld;
         if (rei_vld) rei_q <= rei_cnt;
         if (in_vld) begin
            if (ins_en && is_b1 && b1_armed)      out_byte <= b1_lat;
            else if (ins_en && is_b2 && b2_armed) out_byte <= b2_sel;
            else if (ins_en && is_m1)             out_byte <= rei_byte;
            else                                  out_byte <= din;
         end
      end
   end

   // R7: pass-through when insertion is off
   a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !$past(ins_en)) |-> (out_byte == $past(din)));
   // R10: no output byte without an input byte
   a_r10_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(in_vld));
endmodule

// File: rtl/section_bip_monitor.sv
module section_bip_monitor #(
   parameter int N          = 1,
   parameter int ROWS       = 9,
   parameter int COLS_PER_N = 270,
   parameter int RSOH_ROWS  = 3,
   parameter int B1_ROW     = 1,
   parameter int B1_COL     = 0,
   parameter int B2_ROW     = 4,
   parameter int M1_ROW     = 8,
   parameter int M1_COL     = 5,
   localparam int COLS   = COLS_PER_N * N,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS),
   localparam int LANES  = 3 * N,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int B1_CW  = 4,
   localparam int B2_CW  = $clog2(8 * LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic [7:0]        line_byte,
   input  logic [7:0]        data_byte,
   input  logic              ins_en,
   output logic [B1_CW-1:0]  b1_err_cnt,
   output logic              b1_err_vld,
   output logic [B2_CW-1:0]  b2_err_cnt,
   output logic              b2_err_vld,
   output logic              out_vld,
   output logic [7:0]        out_byte
);
   generate
      if (N < 1) begin : g_bad_n
         $error("section_bip_monitor: N must be at least 1");
      end
      if (COLS % LANES != 0) begin : g_bad_cols
         $error("section_bip_monitor: row length must be a multiple of the lane count");
      end
      if (B2_ROW < RSOH_ROWS || B2_ROW >= ROWS) begin : g_bad_b2
         $error("section_bip_monitor: multiplex parity row outside the covered rows");
      end
      if (B1_ROW >= ROWS || M1_ROW >= ROWS || M1_COL >= COLS || B1_COL >= COLS) begin : g_bad_pos
         $error("section_bip_monitor: overhead position outside the frame");
      end
      if (M1_ROW == B2_ROW && M1_COL < LANES) begin : g_bad_m1
         $error("section_bip_monitor: remote-error byte overlaps parity bytes");
      end
   endgenerate

   logic               sof, is_b1, is_b2, is_m1, in_ms;
   logic [LANE_W-1:0]  b2_lane;
   logic [7:0]         b1_lat;
   logic [LANES*8-1:0] b2_lat;
   logic               b1_armed, b2_armed;

   assign sof     = (row == '0) && (col == '0);
   assign in_ms   = (row >= ROW_W'(RSOH_ROWS));
   assign is_b1   = (row == ROW_W'(B1_ROW)) && (col == COL_W'(B1_COL));
   assign is_b2   = (row == ROW_W'(B2_ROW)) && (col < COL_W'(LANES));
   assign is_m1   = (row == ROW_W'(M1_ROW)) && (col == COL_W'(M1_COL));
   assign b2_lane = LANE_W'(col % COL_W'(LANES));

   sbm_bip_acc #(.LANES(1), .LANE_W(1)) u_acc_rs (
      .clk(clk), .rst_n(rst_n), .in_vld(byte_vld), .sof(sof),
      .in_region(1'b1), .lane(1'b0), .din(line_byte),
      .par_lat(b1_lat), .armed(b1_armed));

   sbm_bip_acc #(.LANES(LANES), .LANE_W(LANE_W)) u_acc_ms (
      .clk(clk), .rst_n(rst_n), .in_vld(byte_vld), .sof(sof),
      .in_region(in_ms), .lane(b2_lane), .din(data_byte),
      .par_lat(b2_lat), .armed(b2_armed));

   sbm_err_check #(.LANES(1), .LANE_W(1), .CW(B1_CW)) u_chk_rs (
      .clk(clk), .rst_n(rst_n), .in_vld(byte_vld), .hit(is_b1),
      .lane(1'b0), .din(data_byte), .par_lat(b1_lat), .armed(b1_armed),
      .err_cnt(b1_err_cnt), .err_vld(b1_err_vld));

   sbm_err_check #(.LANES(LANES), .LANE_W(LANE_W), .CW(B2_CW)) u_chk_ms (
      .clk(clk), .rst_n(rst_n), .in_vld(byte_vld), .hit(is_b2),
      .lane(b2_lane), .din(data_byte), .par_lat(b2_lat), .armed(b2_armed),
      .err_cnt(b2_err_cnt), .err_vld(b2_err_vld));

   sbm_ovh_insert #(.LANES(LANES), .LANE_W(LANE_W), .CW(B2_CW)) u_ins (
      .clk(clk), .rst_n(rst_n), .in_vld(byte_vld), .din(data_byte),
      .ins_en(ins_en), .is_b1(is_b1), .is_b2(is_b2), .is_m1(is_m1),
      .lane(b2_lane), .b1_lat(b1_lat), .b2_lat(b2_lat),
      .b1_armed(b1_armed), .b2_armed(b2_armed),
      .rei_cnt(b2_err_cnt), .rei_vld(b2_err_vld),
      .out_vld(out_vld), .out_byte(out_byte));

   // R9: quiet outputs straight after reset
   a_r9_reset_quiet: assert property (@(posedge clk)
      $past(!rst_n) |-> (!out_vld && !b1_err_vld && !b2_err_vld));
endmodule

// File: tb/sim_section_bip_monitor.sv
module sim_section_bip_monitor;
   localparam int NR = 9;
   localparam int NC = 270;
   localparam int NL = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [3:0] row = '0;
   logic [8:0] col = '0;
   logic [7:0] line_byte = '0;
   logic [7:0] data_byte = '0;
   logic       ins_en = 1'b0;
   logic [3:0] b1_err_cnt;
   logic       b1_err_vld;
   logic [4:0] b2_err_cnt;
   logic       b2_err_vld;
   logic       out_vld;
   logic [7:0] out_byte;

   always #2.5 clk = ~clk;

   section_bip_monitor u0 (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .row(row), .col(col),
      .line_byte(line_byte), .data_byte(data_byte), .ins_en(ins_en),
      .b1_err_cnt(b1_err_cnt), .b1_err_vld(b1_err_vld),
      .b2_err_cnt(b2_err_cnt), .b2_err_vld(b2_err_vld),
      .out_vld(out_vld), .out_byte(out_byte));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int cap_b1_n, cap_b1_v, cap_b2_n, cap_b2_v;
   int frames = 0;
   int exp_rei = 0;
   logic [7:0] act_b1, snt_b1, pact_b1, psnt_b1;
   logic [7:0] act_b2 [NL];
   logic [7:0] snt_b2 [NL];
   logic [7:0] pact_b2 [NL];
   logic [7:0] psnt_b2 [NL];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (b1_err_vld) begin cap_b1_n++; cap_b1_v = int'(b1_err_cnt); end
      if (b2_err_vld) begin cap_b2_n++; cap_b2_v = int'(b2_err_cnt); end
   end

   function automatic logic [7:0] content(int f, int r, int c);
      return 8'((f * 37 + r * 91 + c * 13) ^ (c >> 1));
   endfunction
   function automatic logic [7:0] scr_pat(int r, int c);
      return 8'(r * 29 + c * 7 + 5);
   endfunction

   task automatic run_frame(input string cnt_req, input logic [7:0] b1_ovm,
                            input logic [23:0] b2_ovm, input int er, input int ec,
                            input logic [7:0] scr_err, input logic [7:0] dat_err,
                            input bit ins, input bit gaps);
      bit armed;
      int exp1, exp2;
      bit pend;
      logic [7:0] pend_exp;
      string pend_req;
      armed = (frames >= 1);
      exp1 = $countones(pact_b1 ^ psnt_b1 ^ b1_ovm);
      exp2 = 0;
      for (int l = 0; l < NL; l++)
         exp2 += $countones(pact_b2[l] ^ psnt_b2[l] ^ b2_ovm[l*8 +: 8]);
      if (armed) exp_rei = exp2;
      cap_b1_n = 0; cap_b2_n = 0;
      pend = 1'b0; pend_exp = '0; pend_req = "R7";
      ins_en = ins;
      for (int r = 0; r < NR; r++) begin
         for (int c = 0; c < NC; c++) begin
            logic [7:0] cp, cs, dp, ds, ex;
            @(negedge clk);
            if (pend) chk(out_vld && out_byte == pend_exp, pend_req, "out_byte",
                          int'(out_byte), int'(pend_exp));
            pend = 1'b0;
            if (gaps && c == 100 && (r % 2) == 0) begin
               byte_vld = 1'b0; row = '0; col = '0;
               line_byte = 8'hA5; data_byte = 8'h5A;
               @(negedge clk);
               chk(out_vld == 1'b0, "R10", "out_vld on idle", int'(out_vld), 0);
            end
            if (r == 1 && c == 0)      cp = psnt_b1 ^ b1_ovm;
            else if (r == 4 && c < NL) cp = psnt_b2[c] ^ b2_ovm[c*8 +: 8];
            else                       cp = content(frames, r, c);
            cs = cp ^ scr_pat(r, c);
            dp = cp; ds = cs;
            if (r == er && c == ec) begin dp = cp ^ dat_err; ds = cs ^ scr_err; end
            snt_b1 ^= cs; act_b1 ^= ds;
            if (r >= 3) begin
               snt_b2[c % NL] ^= cp; act_b2[c % NL] ^= dp;
            end
            if (ins && armed && r == 1 && c == 0) begin ex = pact_b1; pend_req = "R1"; end
            else if (ins && armed && r == 4 && c < NL) begin ex = pact_b2[c]; pend_req = "R2"; end
            else if (ins && r == 8 && c == 5) begin ex = 8'(exp_rei); pend_req = "R8"; end
            else begin ex = dp; pend_req = (armed || !ins) ? "R7" : "R5"; end
            byte_vld = 1'b1; row = 4'(r); col = 9'(c);
            line_byte = ds; data_byte = dp;
            pend = 1'b1; pend_exp = ex;
         end
      end
      @(negedge clk);
      if (pend) chk(out_vld && out_byte == pend_exp, pend_req, "out_byte",
                    int'(out_byte), int'(pend_exp));
      byte_vld = 1'b0;
      pact_b1 = act_b1; psnt_b1 = snt_b1; act_b1 = '0; snt_b1 = '0;
      for (int l = 0; l < NL; l++) begin
         pact_b2[l] = act_b2[l]; psnt_b2[l] = snt_b2[l];
         act_b2[l] = '0; snt_b2[l] = '0;
      end
      if (armed) begin
         chk(cap_b1_n == 1 && cap_b1_v == exp1, cnt_req, "b1 count (R3)", cap_b1_v, exp1);
         chk(cap_b2_n == 1 && cap_b2_v == exp2, cnt_req, "b2 count (R4)", cap_b2_v, exp2);
      end else begin
         chk(cap_b1_n == 0, "R5", "b1 pulses before arm", cap_b1_n, 0);
         chk(cap_b2_n == 0, "R5", "b2 pulses before arm", cap_b2_n, 0);
      end
      frames++;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(out_vld == 0 && out_byte == 0, "R9", "out after reset", int'(out_byte), 0);
      chk(!b1_err_vld && !b2_err_vld, "R9", "pulses in reset",
          int'(b1_err_vld) + int'(b2_err_vld), 0);
      chk(b1_err_cnt == 0 && b2_err_cnt == 0, "R9", "counts in reset",
          int'(b1_err_cnt) + int'(b2_err_cnt), 0);
      rst_n = 1'b1;
   endtask

   // R5: first frame, insertion requested but nothing frozen yet
   task automatic t_first_frame;  run_frame("R5", 8'h00, 24'h0, -1, -1, 8'h00, 8'h00, 1'b1, 1'b0); endtask
   // R3/R4: clean frame reports zero
   task automatic t_clean;        run_frame("R3", 8'h00, 24'h0, -1, -1, 8'h00, 8'h00, 1'b0, 1'b0); endtask
   task automatic t_b1_single;    run_frame("R3", 8'h01, 24'h0, -1, -1, 8'h00, 8'h00, 1'b0, 1'b0); endtask
   // R4: all 24 multiplex bits and all 8 regenerator bits wrong
   task automatic t_all_wrong;    run_frame("R4", 8'hFF, 24'hFFFFFF, -1, -1, 8'h00, 8'h00, 1'b0, 1'b0); endtask
   // R4/R8: mixed lanes, remote-error byte carries 3
   task automatic t_lanes_mixed;  run_frame("R4", 8'h00, 24'h800003, -1, -1, 8'h00, 8'h00, 1'b1, 1'b0); endtask
   // R6: descrambled corruption in the regenerator rows
   task automatic t_rsoh_corrupt; run_frame("R6", 8'h00, 24'h0, 0, 100, 8'h00, 8'hFF, 1'b0, 1'b0); endtask
   // R6: line-only corruption in a multiplex row
   task automatic t_line_corrupt; run_frame("R6", 8'h00, 24'h0, 5, 31, 8'h0F, 8'h00, 1'b0, 1'b0); endtask
   // R6/R10: descrambled corruption (lane 2) with idle gaps carrying fake frame starts
   task automatic t_data_gaps;    run_frame("R6", 8'h00, 24'h0, 6, 8, 8'h00, 8'h11, 1'b0, 1'b1); endtask
   // R1/R2/R8: insertion of frozen parities and a count of 2
   task automatic t_insert;       run_frame("R6", 8'h00, 24'h0, -1, -1, 8'h00, 8'h00, 1'b1, 1'b0); endtask
   task automatic t_insert_full;  run_frame("R8", 8'h00, 24'hFFFFFF, -1, -1, 8'h00, 8'h00, 1'b1, 1'b0); endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      act_b1 = '0; snt_b1 = '0; pact_b1 = '0; psnt_b1 = '0;
      for (int l = 0; l < NL; l++) begin
         act_b2[l] = '0; snt_b2[l] = '0; pact_b2[l] = '0; psnt_b2[l] = '0;
      end
      t_reset();
      t_first_frame();
      t_clean();
      t_b1_single();
      t_all_wrong();
      t_lanes_mixed();
      t_rsoh_corrupt();
      t_line_corrupt();
      t_data_gaps();
      t_insert();
      t_insert_full();
      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired act=0 exp=1");
         summary();
         $finish;
      end
   end
endmodule